// File: doc/BRIEF.md
# Mapped Serial-Flash Read Front-End

This block lets a requester read serial NOR flash as if it were memory. A word read on the request port becomes a serial read transaction on a single-lane SPI bus (mode 0, one bit per two system clocks). The transaction is an optional command byte, a 24-bit or 32-bit byte address, an optional option byte, optional dummy clocks and then the data. A small line cache can be filled by bursts, so reads that land on an already fetched line return at once, without touching the flash.

All phase settings are plain configuration pins held stable by the surrounding logic. A mode pin hands the flash to a separate manual engine; while it is set, this block accepts no reads. A flush pin drops the cached line. It must be pulsed whenever a setting that shapes the line changes: the burst length, the address size or the extension bits. The byte address sent to the flash is built from the extension field as the upper bits and the request word address below it.

Back-pressure: a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that acceptance until the response has been taken. `resp_valid` then stays high with `resp_data` unchanged until a cycle where `resp_ready` is high.

Top module: `flash_map_reader`

## Requirements
- R1: While `cfg_manual` is 1, `req_ready` is 0 and no flash transaction is started. Once it returns to 0, a pending request is accepted.
- R2: A transaction sends, MSB first on `spi_mosi`, the command byte `cfg_cmd` (only if `cfg_cmd_en`=1), then the address, then `cfg_opt` (only if `cfg_opt_en`=1), then `cfg_dummy_m1`+1 idle clocks (only if `cfg_dummy_en`=1), then reads data. `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is sampled on the rising `spi_sclk`. Each data word is 32 bits, MSB first.
- R3: `cfg_asz` = 3'b001 sends the low 24 bits of the byte address. Any other value sends all 32 bits.
- R4: The byte address is {zeros, `cfg_ext` (bits 28:25), word address (bits 24:2), 2'b00}. A line is cached under both the extension and the word address.
- R5: With `cfg_burst_en`=0, every read fetches exactly one word, and a repeated read goes to the flash again.
- R6: With `cfg_burst_en`=1, a miss fetches `cfg_burst_m1`+1 words, starting at the word address with the bits set in `cfg_burst_m1` cleared. `cfg_burst_m1` must be 2^k-1. The response is the requested word.
- R7: With `cfg_burst_en`=1, a read whose line is cached starts no transaction, and `resp_valid` is high on the cycle after acceptance.
- R8: A `cfg_flush` pulse invalidates the cached line, so the next read of it fetches from the flash.
- R9: With `cfg_cs_release`=1, `spi_cs_n` goes high right after the last data bit. With 0, it stays low until the next transaction, which first raises it for one cycle.
- R10: `resp_valid` holds with stable `resp_data` until `resp_ready`, and `req_ready` stays low meanwhile.
- R11: After reset, `spi_cs_n`=1, `spi_sclk`=0, `resp_valid`=0 and `req_ready`=1 (with `cfg_manual`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_manual | input | 1 | 1: flash owned by the manual engine, mapped reads blocked |
| cfg_burst_en | input | 1 | Enable burst fills of the line cache |
| cfg_burst_m1 | input | IDX_W | Burst length minus one, in words |
| cfg_flush | input | 1 | Pulse to invalidate the cached line |
| cfg_cs_release | input | 1 | Release chip select after each transaction |
| cfg_ext | input | EXT_W | Upper byte-address bits above the window |
| cfg_asz | input | 3 | Address size code (1 = 24-bit, else 32-bit) |
| cfg_cmd_en | input | 1 | Send the command byte |
| cfg_cmd | input | 8 | Command byte |
| cfg_opt_en | input | 1 | Send the option byte |
| cfg_opt | input | 8 | Option byte |
| cfg_dummy_en | input | 1 | Insert dummy clocks |
| cfg_dummy_m1 | input | 5 | Dummy clock count minus one |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted this cycle when valid |
| req_addr | input | WIN_AW | Word address inside the window |
| resp_valid | output | 1 | Read data valid |
| resp_ready | input | 1 | Requester takes the read data |
| resp_data | output | 32 | Read data |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A table of reads is run with burst fills off, then on. It separates a plain single-word fetch, an aligned burst miss, a hit inside the line, a miss on a neighbouring line, and a miss that differs only in the extension bits. A flash model in the bench decodes the serial header, so the command, address and option seen on the pins are compared with the expected values. This is done in 24-bit and 32-bit address modes and with the command phase removed. Directed cases cover the manual-mode block, the flush, chip select held versus released, and a stalled response.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
  localparam int WORD_W = 32;
  localparam logic [2:0] ASZ_24 = 3'd1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_CMD, PH_ADDR, PH_OPT, PH_DUMMY, PH_DATA, PH_END
  } phase_e;

  typedef enum logic [1:0] {T_IDLE, T_FILL, T_RESP} top_st_e;

  typedef struct packed {
    logic       cmd_en;
    logic [7:0] cmd;
    logic       opt_en;
    logic [7:0] opt;
    logic       dummy_en;
    logic [4:0] dummy_m1;
    logic       addr32;
  } hdr_cfg_t;
endpackage

// File: rtl/fmr_shifter.sv
module fmr_shifter
  import fmr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  hdr_cfg_t           cfg,
  input  logic [31:0]        flash_addr,
  input  logic [IDX_W-1:0]   nwords_m1,
  input  logic               cs_release,
  output logic               word_valid,
  output logic [IDX_W-1:0]   word_idx,
  output logic [WORD_W-1:0]  word_data,
  output logic               done,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  phase_e ph, nxt_ph;
  hdr_cfg_t cfg_q;
  logic [31:0] addr_q, tx_sr, nxt_ld;
  logic [WORD_W-1:0] rx_sr;
  logic [5:0] bitcnt;
  logic [IDX_W-1:0] wcnt, nw_q;

  function automatic phase_e follow(phase_e p, hdr_cfg_t c);
    case (p)
      PH_GAP:  return c.cmd_en ? PH_CMD : PH_ADDR;
      PH_CMD:  return PH_ADDR;
      PH_ADDR: return c.opt_en ? PH_OPT : (c.dummy_en ? PH_DUMMY : PH_DATA);
      PH_OPT:  return c.dummy_en ? PH_DUMMY : PH_DATA;
      PH_DUMMY: return PH_DATA;
      default: return PH_END;
    endcase
  endfunction

  function automatic logic [31:0] payload(phase_e p, hdr_cfg_t c, logic [31:0] a);
    case (p)
      PH_CMD:  return {c.cmd, 24'h0};
      PH_ADDR: return c.addr32 ? a : {a[23:0], 8'h0};
      PH_OPT:  return {c.opt, 24'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [5:0] last_bit(phase_e p, hdr_cfg_t c);
    case (p)
      PH_CMD, PH_OPT: return 6'd7;
      PH_ADDR:  return c.addr32 ? 6'd31 : 6'd23;
      PH_DUMMY: return {1'b0, c.dummy_m1};
      PH_DATA:  return 6'(WORD_W - 1);
      default:  return 6'd0;
    endcase
  endfunction

  always_comb begin
    nxt_ph = follow(ph, cfg_q);
    nxt_ld = payload(nxt_ph, cfg_q, addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
      cfg_q <= '0;
      addr_q <= '0;
      nw_q <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      bitcnt <= '0;
      wcnt <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      mosi <= 1'b0;
      word_valid <= 1'b0;
      word_idx <= '0;
      word_data <= '0;
      done <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          cfg_q <= cfg;
          addr_q <= flash_addr;
          nw_q <= nwords_m1;
          cs_n <= 1'b1;
          ph <= PH_GAP;
        end
        PH_GAP: begin
          cs_n <= 1'b0;
          ph <= nxt_ph;
          tx_sr <= nxt_ld;
          mosi <= nxt_ld[31];
          bitcnt <= '0;
          wcnt <= '0;
        end
        PH_END: begin
          cs_n <= cs_release;
          done <= 1'b1;
          ph <= PH_IDLE;
        end
        default: begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (ph == PH_DATA) rx_sr <= {rx_sr[WORD_W-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitcnt == last_bit(ph, cfg_q)) begin
              bitcnt <= '0;
              if (ph == PH_DATA) begin
                word_valid <= 1'b1;
                word_idx <= wcnt;
                word_data <= rx_sr;
                if (wcnt == nw_q) ph <= PH_END;
                else wcnt <= wcnt + 1'b1;
                mosi <= 1'b0;
              end else begin
                ph <= nxt_ph;
                tx_sr <= nxt_ld;
                mosi <= nxt_ld[31];
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
              tx_sr <= {tx_sr[30:0], 1'b0};
              mosi <= tx_sr[30];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fmr_line_cache.sv
module fmr_line_cache
  import fmr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TAG_W = 27,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              set_tag,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              commit,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  lookup_tag,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              hit,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [TAG_W-1:0] tag_q;
  logic valid, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      armed <= 1'b0;
      tag_q <= '0;
    end else if (flush) begin
      valid <= 1'b0;
      armed <= 1'b0;
    end else if (set_tag) begin
      tag_q <= tag_in;
      valid <= 1'b0;
      armed <= 1'b1;
    end else if (commit) begin
      valid <= armed;
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign hit = valid && (tag_q == lookup_tag);
  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_map_reader.sv
module flash_map_reader
  import fmr_pkg::*;
#(
  parameter int WIN_AW = 23,
  parameter int EXT_W = 4,
  parameter int MAX_BURST = 32,
  localparam int IDX_W = $clog2(MAX_BURST),
  localparam int TAG_W = EXT_W + WIN_AW,
  localparam int BA_W = EXT_W + WIN_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_manual,
  input  logic              cfg_burst_en,
  input  logic [IDX_W-1:0]  cfg_burst_m1,
  input  logic              cfg_flush,
  input  logic              cfg_cs_release,
  input  logic [EXT_W-1:0]  cfg_ext,
  input  logic [2:0]        cfg_asz,
  input  logic              cfg_cmd_en,
  input  logic [7:0]        cfg_cmd,
  input  logic              cfg_opt_en,
  input  logic [7:0]        cfg_opt,
  input  logic              cfg_dummy_en,
  input  logic [4:0]        cfg_dummy_m1,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WIN_AW-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_data,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  top_st_e st;
  hdr_cfg_t hcfg;
  logic [WIN_AW-1:0] mask, aligned, fetch_wa;
  logic [IDX_W-1:0] offset, want;
  logic [31:0] flash_addr;
  logic accept, use_hit, start, burst_q;
  logic c_hit, word_valid, xfer_done;
  logic [IDX_W-1:0] word_idx;
  logic [WORD_W-1:0] word_data, c_rd, resp_q;

  assign hcfg = '{cmd_en: cfg_cmd_en, cmd: cfg_cmd, opt_en: cfg_opt_en,
                  opt: cfg_opt, dummy_en: cfg_dummy_en,
                  dummy_m1: cfg_dummy_m1, addr32: (cfg_asz != ASZ_24)};

  assign mask = {{(WIN_AW-IDX_W){1'b0}}, cfg_burst_m1};
  assign aligned = req_addr & ~mask;
  assign offset = req_addr[IDX_W-1:0] & cfg_burst_m1;
  assign fetch_wa = cfg_burst_en ? aligned : req_addr;
  assign flash_addr = {{(32-BA_W){1'b0}}, cfg_ext, fetch_wa, 2'b00};

  assign req_ready = (st == T_IDLE) && !cfg_manual;
  assign accept = req_valid && req_ready;
  assign use_hit = cfg_burst_en && c_hit;
  assign start = accept && !use_hit;
  assign resp_valid = (st == T_RESP);
  assign resp_data = resp_q;

  fmr_shifter #(.IDX_W(IDX_W)) u_shift (
    .clk, .rst_n, .start, .cfg(hcfg), .flash_addr,
    .nwords_m1(cfg_burst_en ? cfg_burst_m1 : '0),
    .cs_release(cfg_cs_release), .word_valid, .word_idx, .word_data,
    .done(xfer_done), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .miso(spi_miso)
  );

  fmr_line_cache #(.DEPTH(MAX_BURST), .TAG_W(TAG_W)) u_cache (
    .clk, .rst_n, .flush(cfg_flush),
    .set_tag(start && cfg_burst_en), .tag_in({cfg_ext, aligned}),
    .commit(xfer_done && burst_q),
    .wr_en(word_valid && burst_q), .wr_idx(word_idx), .wr_data(word_data),
    .lookup_tag({cfg_ext, aligned}), .rd_idx(offset),
    .hit(c_hit), .rd_data(c_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE;
      resp_q <= '0;
      want <= '0;
      burst_q <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (accept) begin
          if (use_hit) begin
            resp_q <= c_rd;
            st <= T_RESP;
          end else begin
            want <= cfg_burst_en ? offset : '0;
            burst_q <= cfg_burst_en;
            st <= T_FILL;
          end
        end
        T_FILL: begin
          if (word_valid && word_idx == want) resp_q <= word_data;
          if (xfer_done) st <= T_RESP;
        end
        default: if (resp_ready) st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fmr_checker.sv
module fmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_manual,
  input logic        cfg_cs_release,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_data,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        xfer_done
);
  a_r1_manual_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_manual |-> !req_ready);

  a_r2_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r10_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  a_r9_select_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (spi_cs_n == $past(cfg_cs_release)));
endmodule

bind flash_map_reader fmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_manual(cfg_manual),
  .cfg_cs_release(cfg_cs_release), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .xfer_done(xfer_done)
);

// File: tb/test_flash_map_reader.sv
module test_flash_map_reader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_manual = 0, cfg_burst_en = 0, cfg_flush = 0, cfg_cs_release = 1;
  logic [4:0] cfg_burst_m1 = 0, cfg_dummy_m1 = 5'd7;
  logic [3:0] cfg_ext = 0;
  logic [2:0] cfg_asz = 3'd1;
  logic cfg_cmd_en = 1, cfg_opt_en = 0, cfg_dummy_en = 1;
  logic [7:0] cfg_cmd = 8'h0B, cfg_opt = 8'h00;
  logic req_valid = 0, resp_ready = 1, req_ready, resp_valid;
  logic [22:0] req_addr = 0;
  logic [31:0] resp_data;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_map_reader i_flash_map_reader (.*);

  // flash model
  int xfer_cnt = 0, rise_cnt = 0;
  logic [63:0] hdr;
  logic [31:0] cap_addr, cap_opt, cap_cmd;

  function automatic logic [31:0] fdat(logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_A5A5;
  endfunction
  function automatic int ab_bits();
    return (cfg_asz == 3'd1) ? 24 : 32;
  endfunction
  function automatic int db_bits();
    return cfg_dummy_en ? int'(cfg_dummy_m1) + 1 : 0;
  endfunction
  function automatic int hdr_bits();
    return (cfg_cmd_en ? 8 : 0) + ab_bits() + (cfg_opt_en ? 8 : 0) + db_bits();
  endfunction

  always @(negedge spi_cs_n) begin
    xfer_cnt++;
    rise_cnt = 0;
    hdr = '0;
  end
  always @(posedge spi_sclk) begin
    int ob;
    if (rise_cnt < hdr_bits()) hdr = {hdr[62:0], spi_mosi};
    rise_cnt++;
    if (rise_cnt == hdr_bits()) begin
      ob = cfg_opt_en ? 8 : 0;
      cap_addr = 32'(hdr >> (ob + db_bits()));
      if (ab_bits() == 24) cap_addr = cap_addr & 32'h00FF_FFFF;
      cap_opt = 32'(hdr >> db_bits()) & 32'hFF;
      cap_cmd = 32'(hdr >> (ob + db_bits() + ab_bits())) & 32'hFF;
    end
  end
  always @(negedge spi_sclk) begin
    int i;
    logic [31:0] w;
    if (rise_cnt >= hdr_bits()) begin
      i = rise_cnt - hdr_bits();
      w = fdat(cap_addr + 32'(4 * (i / 32)));
      spi_miso = w[31 - (i % 32)];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [22:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    req_valid = 1;
    req_addr = a;
    while (!req_ready) @(negedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 0;
      lat++;
    end while (!resp_valid);
    d = resp_data;
    @(negedge clk);
  endtask

  function automatic logic [31:0] byte_addr(logic [3:0] e, logic [22:0] wa);
    logic [31:0] b;
    b = {3'b000, e, wa, 2'b00};
    return (cfg_asz == 3'd1) ? (b & 32'h00FF_FFFF) : b;
  endfunction

  typedef struct packed {
    logic be; logic [4:0] bm1; logic [3:0] ext; logic [22:0] addr; logic hit;
  } vec_t;
  localparam vec_t VEC [0:7] = '{
    '{1'b0, 5'd0, 4'd0, 23'h10, 1'b0},
    '{1'b0, 5'd0, 4'd0, 23'h10, 1'b0},
    '{1'b1, 5'd7, 4'd0, 23'h13, 1'b0},
    '{1'b1, 5'd7, 4'd0, 23'h17, 1'b1},
    '{1'b1, 5'd7, 4'd0, 23'h18, 1'b0},
    '{1'b1, 5'd7, 4'd1, 23'h18, 1'b0},
    '{1'b1, 5'd7, 4'd1, 23'h1B, 1'b1},
    '{1'b1, 5'd7, 4'd0, 23'h10, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, d0;
    int lat, x0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cs_n", 32'(spi_cs_n), 1);
    chk("R11 sclk", 32'(spi_sclk), 0);
    chk("R11 resp_valid", 32'(resp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 req_ready", 32'(req_ready), 1);

    // table walk
    foreach (VEC[k]) begin
      logic [22:0] wa;
      string tg;
      cfg_burst_en = VEC[k].be;
      cfg_burst_m1 = VEC[k].bm1;
      cfg_ext = VEC[k].ext;
      tg = VEC[k].hit ? "R7" : (VEC[k].be ? "R6" : "R5");
      wa = VEC[k].be ? (VEC[k].addr & ~23'(VEC[k].bm1)) : VEC[k].addr;
      x0 = xfer_cnt;
      do_read(VEC[k].addr, d, lat);
      chk("R2 data", d, fdat(byte_addr(VEC[k].ext, VEC[k].addr)));
      if (VEC[k].hit) begin
        chk({tg, " no transaction"}, 32'(xfer_cnt - x0), 0);
        chk({tg, " latency"}, 32'(lat), 1);
      end else begin
        chk({tg, " one transaction"}, 32'(xfer_cnt - x0), 1);
        chk({tg, " words fetched"}, 32'((rise_cnt - hdr_bits()) / 32),
            VEC[k].be ? 32'(VEC[k].bm1) + 1 : 1);
        chk("R4 start address", cap_addr, byte_addr(VEC[k].ext, wa));
        chk("R2 command", cap_cmd, 32'h0B);
      end
    end

    // R3 R4: 32-bit address, option byte, no dummy
    cfg_burst_en = 0; cfg_asz = 3'd3; cfg_ext = 4'hA; cfg_opt_en = 1;
    cfg_opt = 8'h5C; cfg_dummy_en = 0; cfg_cmd = 8'hEC;
    do_read(23'h12345, d, lat);
    chk("R3 32-bit address", cap_addr, {3'b000, 4'hA, 23'h12345, 2'b00});
    chk("R2 option byte", cap_opt, 32'h5C);
    chk("R2 command 32-bit", cap_cmd, 32'hEC);
    chk("R4 data", d, fdat({3'b000, 4'hA, 23'h12345, 2'b00}));

    // R2: command phase removed
    cfg_cmd_en = 0; cfg_asz = 3'd1; cfg_opt_en = 0; cfg_dummy_en = 1; cfg_ext = 0;
    do_read(23'h00321, d, lat);
    chk("R2 no-command address", cap_addr, 32'h00321 << 2);
    chk("R2 no-command data", d, fdat(32'h00321 << 2));
    cfg_cmd_en = 1; cfg_cmd = 8'h0B;

    // R8 flush
    cfg_burst_en = 1; cfg_burst_m1 = 5'd3;
    do_read(23'h40, d, lat);
    x0 = xfer_cnt;
    do_read(23'h41, d, lat);
    chk("R8 hit before flush", 32'(xfer_cnt - x0), 0);
    @(negedge clk); cfg_flush = 1; @(negedge clk); cfg_flush = 0;
    x0 = xfer_cnt;
    do_read(23'h41, d, lat);
    chk("R8 refetch after flush", 32'(xfer_cnt - x0), 1);
    chk("R8 data", d, fdat(32'h41 << 2));

    // R1 manual mode
    cfg_burst_en = 0; cfg_manual = 1; x0 = xfer_cnt;
    @(negedge clk); req_valid = 1; req_addr = 23'h77;
    begin
      int seen = 0;
      repeat (30) begin @(negedge clk); if (req_ready) seen++; end
      chk("R1 no accept in manual", 32'(seen), 0);
    end
    chk("R1 no transaction in manual", 32'(xfer_cnt - x0), 0);
    req_valid = 0; cfg_manual = 0;
    do_read(23'h77, d, lat);
    chk("R1 read after manual", d, fdat(32'h77 << 2));

    // R9 chip select held
    cfg_cs_release = 0;
    do_read(23'h80, d, lat);
    repeat (10) @(negedge clk);
    chk("R9 cs held low", 32'(spi_cs_n), 0);
    x0 = xfer_cnt;
    do_read(23'h81, d, lat);
    chk("R9 new select", 32'(xfer_cnt - x0), 1);
    chk("R9 data", d, fdat(32'h81 << 2));
    cfg_cs_release = 1;
    do_read(23'h82, d, lat);
    chk("R9 cs released", 32'(spi_cs_n), 1);

    // R10 stalled response
    resp_ready = 0;
    @(negedge clk); req_valid = 1; req_addr = 23'h90;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!resp_valid) @(negedge clk);
    d0 = resp_data;
    begin
      int bad = 0;
      repeat (6) begin
        @(negedge clk);
        if (!resp_valid || resp_data !== d0 || req_ready) bad++;
      end
      chk("R10 held response", 32'(bad), 0);
    end
    chk("R10 data", d0, fdat(32'h90 << 2));
    resp_ready = 1;
    @(negedge clk);
    chk("R10 taken", 32'(resp_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule